// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

This block is a register-mapped peripheral holding two independent 32-bit timers. Both count down by one on every clock while enabled. Each timer has two bits in one shared control word: one enables it and one selects auto-reload. Each timer also has a reload register and a current-value register, and software can write either one at any time. A timer whose count has reached zero expires on the next tick. In auto-reload mode it then reloads from its reload register. In one-shot mode it clears its own enable bit and holds at zero.

Every expiry sets a sticky pending bit in a cause register. A mask register selects which pending bits drive the single interrupt output. Software acknowledges a timer by writing its cause bit as zero; bits written as one keep their value.

Typical set-ups:
- **Free-running time base:** load all-ones into both registers and enable auto-reload. Software reads the inverted count to get a rising time.
- **Periodic tick:** load N into both registers and enable auto-reload. The timer expires once every N+1 clocks.
- **Single event:** load a count, clear auto-reload, then enable. The timer raises one event and stops.

Top module: `dual_dntimer`

## Requirements
- R1: After a synchronous active-low reset, the control, cause and mask bits are all zero, all four count and reload registers read zero, and `irq_o` is low.
- R2: The registers sit at these byte offsets, and writes to them read back:
  - control at 0x000
  - timer 0 reload at 0x010 and timer 0 count at 0x014
  - timer 1 reload at 0x018 and timer 1 count at 0x01C
  - cause at 0x110 and mask at 0x114

  Reads of any other offset return zero. Control bits 0 and 1 are the enable and auto-reload bits of timer 0; bits 2 and 3 are the same for timer 1. In cause and mask, bit 1 belongs to timer 0 and bit 2 to timer 1. All other bits read zero.
- R3: An enabled timer with a nonzero count decrements by one each clock. A disabled timer keeps its count.
- R4: An enabled auto-reload timer whose count is zero loads its reload value on the next clock. With reload value N, the count reads N, N-1, ... 0, N and so on, so the timer expires once every N+1 clocks.
- R5: An enabled one-shot timer whose count is zero clears its enable bit on the next clock and stays at zero. After software writes count N and then sets the enable bit, the pending bit first reads set N+1 clocks after that write.
- R6: Every expiry sets the timer's cause bit. A write to the cause register clears each bit that is written as 0 and leaves each bit written as 1 unchanged.
- R7: If an expiry and a clearing cause write fall in the same clock, the cause bit ends up set.
- R8: `irq_o` is high exactly when some cause bit is set and its mask bit is also set. A pending bit stays set while it is masked, and it drives `irq_o` as soon as it is unmasked.
- R9: A bus write to a count register in the same clock as counting or reloading wins over them. A bus write to the control register in the same clock as a one-shot expiry wins over the automatic clearing of the enable bit.
- R10: With all-ones in the reload register and auto-reload enabled, the count wraps from 0 to 0xFFFFFFFF and keeps counting down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; counters tick on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe; the write takes effect at the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt: any cause bit that is pending and unmasked |

## Verification
Two operations can land in the same clock:
- an expiry and a software acknowledge of the same cause bit;
- an expiry and a bus write to that timer's count or control register.

The bench provokes the first by running a short auto-reload period and, in alternating cycles, writing cause with zeros and reading it back. The ordering therefore drifts across the expiry cycle. The second is provoked by writing control or count in the cycle where a loaded zero expires, and random traffic adds many more such collisions. A cycle-level bench model judges each case: set wins over clear, and the bus write wins over reload, decrement and the one-shot clearing of the enable bit.

// File: rtl/dtm_pkg.sv
`timescale 1ns/1ps
// Package: register offsets, bit placement and shared types of the dual
// down-counter timer. Assumes a byte-addressed 12-bit offset space.
package dtm_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int CTRL_BITS  = 2;     // enable, auto-reload per channel
    localparam int TMR_BASE   = 16;    // first reload register offset
    localparam int TMR_STRIDE = 8;     // distance between channel pairs
    localparam int VAL_DELTA  = 4;     // count register follows reload
    localparam int CAUSE_LSB  = 1;     // channel 0 pending bit position

    localparam logic [ADDR_W-1:0] CTRL_OFF  = 12'h000;
    localparam logic [ADDR_W-1:0] CAUSE_OFF = 12'h110;
    localparam logic [ADDR_W-1:0] MASK_OFF  = 12'h114;

    // Offset of the reload register of channel idx.
    function automatic logic [ADDR_W-1:0] reload_off(input int idx);
        return ADDR_W'(TMR_BASE + TMR_STRIDE * idx);
    endfunction

    // Offset of the count register of channel idx.
    function automatic logic [ADDR_W-1:0] value_off(input int idx);
        return ADDR_W'(TMR_BASE + TMR_STRIDE * idx + VAL_DELTA);
    endfunction

    // Per-channel write strobes produced by the decoder.
    typedef struct packed {
        logic ctrl_we;
        logic reload_we;
        logic value_we;
    } ch_wr_t;
endpackage

// File: rtl/dtm_channel.sv
`timescale 1ns/1ps
// Module: one down-counting timer channel with its enable and auto-reload
// bits. Assumes write strobes arrive decoded and are single-cycle.
// Priority: a bus write beats counting, reloading and one-shot self-disable.
module dtm_channel
    import dtm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ch_wr_t           wr,
    input  logic             ctrl_en_d,
    input  logic             ctrl_ar_d,
    input  logic [CNT_W-1:0] wdata,
    output logic             en_q,
    output logic             ar_q,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] value_q,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Expiry: enabled with the count already at zero.
    always_comb expire = en_q && (value_q == '0);

    // Control bits: bus write first, else one-shot self-disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            ar_q <= 1'b0;
        end else if (wr.ctrl_we) begin
            en_q <= ctrl_en_d;
            ar_q <= ctrl_ar_d;
        end else if (expire && !ar_q) begin
            en_q <= 1'b0;
        end
    end

    // Reload register: written only by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr.reload_we) begin
            reload_q <= wdata;
        end
    end

    // Count register: bus load, reload on expiry, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (wr.value_we) begin
            value_q <= wdata;
        end else if (expire) begin
            if (ar_q) begin
                value_q <= reload_q;
            end
        end else if (en_q) begin
            value_q <= value_q - ONE;
        end
    end
endmodule

// File: rtl/dtm_irq_bridge.sv
`timescale 1ns/1ps
// Module: pending/mask interrupt bridge. Cause bits are sticky, set by
// channel expiry and cleared by write-zero; set wins over a same-cycle clear.
// Assumes the write data is already aligned to channel order.
module dtm_irq_bridge #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cause_we,
    input  logic              mask_we,
    input  logic [NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0] expire,
    output logic [NUM_CH-1:0] cause_q,
    output logic [NUM_CH-1:0] mask_q,
    output logic              irq_o
);
    logic [NUM_CH-1:0] cause_kept;

    // Bits surviving a possible write-zero-to-clear access.
    always_comb cause_kept = cause_we ? (cause_q & wdata) : cause_q;

    // Pending bits: survivors plus any new expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_kept | expire;
        end
    end

    // Mask bits: plain bus register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wdata;
        end
    end

    // Interrupt: any pending bit that is unmasked.
    always_comb irq_o = |(cause_q & mask_q);
endmodule

// File: rtl/dtm_regdec.sv
`timescale 1ns/1ps
// Module: register decoder. Turns the bus offset and write strobe into
// per-register write enables, and builds the combinational read word.
// Assumes NUM_CH channels fit below the cause offset and the control word.
module dtm_regdec
    import dtm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_we,
    input  logic [NUM_CH-1:0]             en_q,
    input  logic [NUM_CH-1:0]             ar_q,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  reload_q,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  value_q,
    input  logic [NUM_CH-1:0]             cause_q,
    input  logic [NUM_CH-1:0]             mask_q,
    output ch_wr_t [NUM_CH-1:0]           ch_wr,
    output logic                          cause_we,
    output logic                          mask_we,
    output logic [DATA_W-1:0]             rdata
);
    // Write strobes for the shared and per-channel registers.
    always_comb begin
        cause_we = bus_we && (bus_addr == CAUSE_OFF);
        mask_we  = bus_we && (bus_addr == MASK_OFF);
        for (int i = 0; i < NUM_CH; i++) begin
            ch_wr[i].ctrl_we   = bus_we && (bus_addr == CTRL_OFF);
            ch_wr[i].reload_we = bus_we && (bus_addr == reload_off(i));
            ch_wr[i].value_we  = bus_we && (bus_addr == value_off(i));
        end
    end

    // Read word: zero unless the offset maps to a register.
    always_comb begin
        rdata = '0;
        if (bus_addr == CTRL_OFF) begin
            for (int i = 0; i < NUM_CH; i++) begin
                rdata[CTRL_BITS*i]     = en_q[i];
                rdata[CTRL_BITS*i + 1] = ar_q[i];
            end
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == reload_off(i)) rdata[CNT_W-1:0] = reload_q[i];
            if (bus_addr == value_off(i))  rdata[CNT_W-1:0] = value_q[i];
        end
        if (bus_addr == CAUSE_OFF) rdata[CAUSE_LSB +: NUM_CH] = cause_q;
        if (bus_addr == MASK_OFF)  rdata[CAUSE_LSB +: NUM_CH] = mask_q;
    end
endmodule

// File: rtl/dual_dntimer.sv
`timescale 1ns/1ps
// Module: top of the dual reloadable down-counter timer. Wires the decoder,
// one channel per timer (generated) and the interrupt bridge.
// Assumes a single-cycle register bus with combinational read data.
module dual_dntimer
    import dtm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    ch_wr_t [NUM_CH-1:0]            ch_wr;
    logic                           cause_we;
    logic                           mask_we;
    logic [NUM_CH-1:0]              ch_en;
    logic [NUM_CH-1:0]              ch_ar;
    logic [NUM_CH-1:0]              ch_exp;
    logic [NUM_CH-1:0][CNT_W-1:0]   ch_val;
    logic [NUM_CH-1:0][CNT_W-1:0]   ch_rel;
    logic [NUM_CH-1:0]              cause_q;
    logic [NUM_CH-1:0]              mask_q;

    // Address decode and read mux.
    dtm_regdec #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .en_q     (ch_en),
        .ar_q     (ch_ar),
        .reload_q (ch_rel),
        .value_q  (ch_val),
        .cause_q  (cause_q),
        .mask_q   (mask_q),
        .ch_wr    (ch_wr),
        .cause_we (cause_we),
        .mask_we  (mask_we),
        .rdata    (bus_rdata)
    );

    // One counter channel per timer.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_tmr
        dtm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (ch_wr[i]),
            .ctrl_en_d (bus_wdata[CTRL_BITS*i]),
            .ctrl_ar_d (bus_wdata[CTRL_BITS*i + 1]),
            .wdata     (bus_wdata[CNT_W-1:0]),
            .en_q      (ch_en[i]),
            .ar_q      (ch_ar[i]),
            .reload_q  (ch_rel[i]),
            .value_q   (ch_val[i]),
            .expire    (ch_exp[i])
        );
    end

    // Pending/mask bridge onto the single interrupt line.
    dtm_irq_bridge #(.NUM_CH(NUM_CH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause_we (cause_we),
        .mask_we  (mask_we),
        .wdata    (bus_wdata[CAUSE_LSB +: NUM_CH]),
        .expire   (ch_exp),
        .cause_q  (cause_q),
        .mask_q   (mask_q),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/dntimer_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for dual_dntimer, attached by bind below.
// Observes channel state and the bridge pending bits across cycles.
module dntimer_chk
    import dtm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_we,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [NUM_CH-1:0]             ch_en,
    input logic [NUM_CH-1:0]             ch_ar,
    input logic [NUM_CH-1:0]             ch_exp,
    input logic [NUM_CH-1:0][CNT_W-1:0]  ch_val,
    input logic [NUM_CH-1:0][CNT_W-1:0]  ch_rel,
    input logic [NUM_CH-1:0]             cause_q
);
    logic ctrl_wr;
    logic clr_wr;
    always_comb ctrl_wr = bus_we && (bus_addr == CTRL_OFF);
    always_comb clr_wr  = bus_we && (bus_addr == CAUSE_OFF);

    // R1: the first cycle after reset shows cleared state.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ch_en == '0 && ch_ar == '0 && cause_q == '0
                           && ch_val == '0 && ch_rel == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic val_wr;
        always_comb val_wr = bus_we && (bus_addr == value_off(i));

        // R3: enabled nonzero count decrements by one.
        assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[i] && !ch_exp[i] && !val_wr)
            |=> ch_val[i] == $past(ch_val[i]) - CNT_W'(1));

        // R3: disabled count holds.
        assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[i] && !val_wr) |=> $stable(ch_val[i]));

        // R4: auto-reload expiry loads the reload value.
        assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_exp[i] && ch_ar[i] && !val_wr) |=> ch_val[i] == $past(ch_rel[i]));

        // R5: one-shot expiry disables the channel.
        assert_oneshot_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_exp[i] && !ch_ar[i] && !ctrl_wr) |=> !ch_en[i]);

        // R6: pending bit is sticky without a cause write.
        assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_q[i] && !clr_wr) |=> cause_q[i]);

        // R7: expiry always leaves the pending bit set, clear or not.
        assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ch_exp[i] |=> cause_q[i]);
    end
endmodule

bind dual_dntimer dntimer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .ch_en    (ch_en),
    .ch_ar    (ch_ar),
    .ch_exp   (ch_exp),
    .ch_val   (ch_val),
    .ch_rel   (ch_rel),
    .cause_q  (cause_q)
);

// File: tb/dual_dntimer_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random bus traffic, judged by a
// cycle-level model written from the requirements.
module dual_dntimer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_val [2];
    logic [31:0] m_rel [2];
    logic        m_en  [2];
    logic        m_ar  [2];
    logic        m_cau [2];
    logic        m_msk [2];

    always #5 clk = ~clk;

    dual_dntimer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h000: return {28'b0, m_ar[1], m_en[1], m_ar[0], m_en[0]};
            12'h010: return m_rel[0];
            12'h014: return m_val[0];
            12'h018: return m_rel[1];
            12'h01C: return m_val[1];
            12'h110: return {29'b0, m_cau[1], m_cau[0], 1'b0};
            12'h114: return {29'b0, m_msk[1], m_msk[0], 1'b0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_irq();
        return (m_cau[0] && m_msk[0]) || (m_cau[1] && m_msk[1]);
    endfunction

    // One bus cycle: drive, compare reads and irq, advance the model.
    task automatic cyc(input logic [11:0] a, input logic w, input logic [31:0] d,
                       input string tag);
        logic [31:0] nv [2];
        logic [31:0] nr [2];
        logic ne [2], na [2], nc [2], nm [2];
        logic ex;
        @(negedge clk);
        addr = a; we = w; wdata = d;
        #1;
        if (!w) check(rdata, m_read(a), tag);
        check({31'b0, irq}, {31'b0, m_irq()}, "R8 irq");
        for (int c = 0; c < 2; c++) begin
            ex = m_en[c] && (m_val[c] == 0);
            nv[c] = m_val[c]; nr[c] = m_rel[c]; ne[c] = m_en[c]; na[c] = m_ar[c];
            nc[c] = m_cau[c]; nm[c] = m_msk[c];
            if (w && a == 12'(16 + 8*c + 4)) nv[c] = d;
            else if (ex) nv[c] = m_ar[c] ? m_rel[c] : m_val[c];
            else if (m_en[c]) nv[c] = m_val[c] - 1;
            if (w && a == 12'(16 + 8*c)) nr[c] = d;
            if (w && a == 12'h000) begin ne[c] = d[2*c]; na[c] = d[2*c+1]; end
            else if (ex && !m_ar[c]) ne[c] = 1'b0;
            if (w && a == 12'h110) nc[c] = m_cau[c] & d[c+1];
            nc[c] = nc[c] | ex;
            if (w && a == 12'h114) nm[c] = d[c+1];
        end
        @(posedge clk);
        for (int c = 0; c < 2; c++) begin
            if (!rst_n) begin
                m_val[c] = 0; m_rel[c] = 0; m_en[c] = 0; m_ar[c] = 0;
                m_cau[c] = 0; m_msk[c] = 0;
            end else begin
                m_val[c] = nv[c]; m_rel[c] = nr[c]; m_en[c] = ne[c]; m_ar[c] = na[c];
                m_cau[c] = nc[c]; m_msk[c] = nm[c];
            end
        end
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        cyc(a, 1'b0, 32'h0, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        cyc(a, 1'b1, d, tag);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] raddr [8];
        int first;
        void'($urandom(32'd20240611));
        raddr[0] = 12'h000; raddr[1] = 12'h010; raddr[2] = 12'h014; raddr[3] = 12'h018;
        raddr[4] = 12'h01C; raddr[5] = 12'h110; raddr[6] = 12'h114; raddr[7] = 12'h004;
        for (int c = 0; c < 2; c++) begin
            m_val[c] = 0; m_rel[c] = 0; m_en[c] = 0; m_ar[c] = 0; m_cau[c] = 0; m_msk[c] = 0;
        end
        repeat (3) rd(12'h000, "R1 in reset");
        rst_n = 1'b1;

        // R1: reset state of every register
        for (int k = 0; k < 8; k++) rd(raddr[k], "R1 reset value");
        check({31'b0, irq}, 32'h0, "R1 irq after reset");

        // R2: readback, field placement and unmapped offsets
        wr(12'h010, 32'h1234_5678, "R2");
        rd(12'h010, "R2 reload0 readback");
        wr(12'h018, 32'hCAFE_0001, "R2");
        rd(12'h018, "R2 reload1 readback");
        wr(12'h114, 32'hFFFF_FFFF, "R2");
        rd(12'h114, "R2 mask bits 1 and 2");
        check(rdata, 32'h0000_0006, "R2 mask literal");
        wr(12'h114, 32'h0, "R2");
        rd(12'h020, "R2 unmapped");
        rd(12'h100, "R2 unmapped");

        // R3 hold while disabled, then R5 one-shot timing
        wr(12'h014, 32'd3, "R3");
        rd(12'h014, "R3 hold disabled");
        rd(12'h014, "R3 hold disabled");
        wr(12'h000, 32'h1, "R5");
        first = -1;
        for (int k = 0; k < 8; k++) begin
            rd(12'h110, "R5 cause poll");
            if (first < 0 && rdata[1]) first = k;
        end
        check(32'(first), 32'd4, "R5 expiry after N+1 clocks");
        rd(12'h000, "R5 enable self-cleared");
        check(rdata, 32'h0, "R5 ctrl literal");
        rd(12'h014, "R5 count held at zero");

        // R6: acknowledge one timer only
        wr(12'h01C, 32'd0, "R6");
        wr(12'h000, 32'h4, "R6");
        rd(12'h110, "R6 both pending");
        rd(12'h110, "R6 both pending");
        check(rdata, 32'h6, "R6 bits 1 and 2 literal");
        wr(12'h110, 32'hFFFF_FFFD, "R6");
        rd(12'h110, "R6 only timer0 cleared");
        check(rdata, 32'h4, "R6 timer1 kept literal");
        wr(12'h110, 32'h0, "R6");
        rd(12'h110, "R6 all cleared");

        // R8: masked pending, then unmask
        wr(12'h014, 32'd1, "R8");
        wr(12'h000, 32'h1, "R8");
        repeat (4) rd(12'h110, "R8 pending while masked");
        wr(12'h114, 32'h2, "R8");
        rd(12'h114, "R8 unmasked");
        check({31'b0, irq}, 32'h1, "R8 irq asserted after unmask");
        wr(12'h110, 32'h0, "R8");
        rd(12'h110, "R8 acked");

        // R4: auto-reload period N+1 with N=2
        wr(12'h018, 32'd2, "R4");
        wr(12'h01C, 32'd2, "R4");
        wr(12'h000, 32'hC, "R4");
        for (int k = 0; k < 6; k++) begin
            rd(12'h01C, "R4 reload sequence");
            check(rdata, 32'(2 - (k % 3)), "R4 literal sequence");
        end

        // R7: clear writes drifting across expiries of the period-3 timer
        for (int k = 0; k < 14; k++) begin
            if (k % 2 == 0) wr(12'h110, 32'h0, "R7");
            else rd(12'h110, "R7 set wins over clear");
        end
        wr(12'h000, 32'h0, "R7");

        // R9: control write in the cycle of a one-shot expiry keeps enable
        wr(12'h014, 32'd0, "R9");
        wr(12'h000, 32'h1, "R9");
        wr(12'h000, 32'h1, "R9 ctrl write at expiry");
        rd(12'h000, "R9 ctrl write wins");
        check(rdata, 32'h1, "R9 enable kept literal");
        wr(12'h014, 32'd5, "R9 value write while counting");
        rd(12'h014, "R9 value write wins");
        check(rdata, 32'd5, "R9 value literal");

        // R10: free-running wrap
        wr(12'h000, 32'h0, "R10");
        wr(12'h010, 32'hFFFF_FFFF, "R10");
        wr(12'h014, 32'd1, "R10");
        wr(12'h000, 32'h3, "R10");
        rd(12'h014, "R10 wrap"); check(rdata, 32'd1, "R10 literal");
        rd(12'h014, "R10 wrap"); check(rdata, 32'd0, "R10 literal");
        rd(12'h014, "R10 wrap"); check(rdata, 32'hFFFF_FFFF, "R10 literal");
        rd(12'h014, "R10 wrap"); check(rdata, 32'hFFFF_FFFE, "R10 literal");

        // Random traffic: R2 R3 R4 R5 R6 R7 R8 R9 against the model
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = int'($urandom % 10);
            case (op)
                0: wr(12'h000, $urandom % 16, "R9 random ctrl");
                1: wr(12'h010, $urandom % 8, "R4 random");
                2: wr(12'h014, $urandom % 8, "R3 random");
                3: wr(12'h018, $urandom % 8, "R4 random");
                4: wr(12'h01C, $urandom % 8, "R3 random");
                5: wr(12'h110, $urandom, "R7 random clear");
                6: wr(12'h114, $urandom, "R8 random mask");
                default: rd(raddr[$urandom % 8], "R2 random read");
            endcase
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule